// File: doc/BRIEF.md
# Bunch-Train Power-Pulsing Sequencer

This block steps a detector front end through the phases of an accelerator bunch-train cycle. A train-start strobe wakes the analog supplies. A programmable settling delay follows. The block then counts bunch crossings over the acquisition window. Next come a bounded conversion phase and a bounded readout phase, each with its own power enable. After readout the block returns to an idle phase in which every supply is switched off. It waits there until the next train. The idle phase fills about 99% of the cycle. Data taken during the train stays on chip and leaves only in the gap before the next train.

All durations are counted in clock cycles, and each terminal count is a parameter. A fast simulation can therefore shrink the cycle without changing the sequence. Conversion and readout each end early when their done flag arrives. If the done flag does not arrive in time, a timeout forces the step and sets a sticky overrun flag. A train-start strobe that arrives while a cycle is already running is dropped, and a saturating error counter records it.

Top module: `pwrcyc_seq`

## Requirements
- R1: After reset, or whenever the phase is idle, `phase_o` is 0, every power enable and `acq_o` are low, and the overrun flags and `err_cnt_o` hold 0 until the first event that changes them.
- R2: A `train_start_i` pulse in the idle phase moves the phase to wake (1) on the next clock edge. Wake lasts exactly `WAKE_CYC` cycles, and only `pwr_ana_o` is high during it.
- R3: The acquisition phase (2) follows wake. It lasts exactly `BX_PER*N_BX` cycles, with `acq_o` and `pwr_ana_o` high throughout.
- R4: `bx_strobe_o` is high for one cycle at the start of every crossing period of `BX_PER` cycles. That gives exactly `N_BX` pulses per train, and the strobe is never high outside acquisition.
- R5: The conversion phase (3) has only `pwr_adc_o` high. A `conv_done_i` seen during conversion moves the phase to readout on the next edge. This holds even on the last allowed cycle, and `ovr_conv_o` is not set.
- R6: If conversion lasts `CONV_TO` cycles without `conv_done_i`, the phase moves to readout and `ovr_conv_o` goes high. The flag stays high until reset.
- R7: The readout phase (4) has only `pwr_dout_o` high. A `rd_done_i` seen during readout returns the phase to idle on the next edge without setting `ovr_read_o`.
- R8: If readout lasts `READ_TO` cycles without `rd_done_i`, the phase returns to idle and `ovr_read_o` goes high. The flag stays high until reset.
- R9: A `train_start_i` outside the idle phase leaves the phase sequence unchanged. Each such cycle adds one to `err_cnt_o`, which saturates at all ones.
- R10: `conv_done_i` outside conversion and `rd_done_i` outside readout have no effect on the phase sequence.
- R11: At most one of the three power enables is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start_i | input | 1 | Strobe marking the start of a bunch train |
| conv_done_i | input | 1 | Conversion stage finished |
| rd_done_i | input | 1 | Readout stage finished |
| phase_o | output | 3 | Phase: 0 idle, 1 wake, 2 acquire, 3 convert, 4 readout |
| pwr_ana_o | output | 1 | Analog front-end supply enable |
| pwr_adc_o | output | 1 | Conversion supply enable |
| pwr_dout_o | output | 1 | Readout supply enable |
| acq_o | output | 1 | Acquisition window active |
| bx_strobe_o | output | 1 | One-cycle pulse per bunch crossing |
| ovr_conv_o | output | 1 | Sticky conversion timeout flag |
| ovr_read_o | output | 1 | Sticky readout timeout flag |
| err_cnt_o | output | ERR_W | Saturating count of stray train starts |

## Verification
The bench builds the block with a 5-cycle wake, 3-cycle crossings, 4 crossings per train, a conversion timeout of 6 and a readout timeout of 7. A complete cycle then takes only a few dozen clocks, so every cycle of several trains can be compared in order. A 3-bit error counter lets a handful of stray starts reach saturation. The short timeouts make it cheap to place a done flag on the very cycle the timeout would fire, and to let each timeout expire.

// File: rtl/pwrcyc_pkg.sv
`timescale 1ns/1ps
package pwrcyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAKE = 3'd1,
    PH_ACQ  = 3'd2,
    PH_CONV = 3'd3,
    PH_READ = 3'd4
  } phase_e;

  typedef struct packed {
    logic ana;
    logic adc;
    logic dout;
  } dom_t;

  // Supply domains that each phase keeps powered.
  function automatic dom_t dom_of(phase_e p);
    dom_t d;
    d = '0;
    case (p)
      PH_WAKE, PH_ACQ: d.ana  = 1'b1;
      PH_CONV:         d.adc  = 1'b1;
      PH_READ:         d.dout = 1'b1;
      default:         d      = '0;
    endcase
    return d;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Length of the acquisition window in clock cycles.
  function automatic int unsigned acq_len(int unsigned per, int unsigned n);
    return per * n;
  endfunction

  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pwrcyc_span_cnt.sv
`timescale 1ns/1ps
// Cycle counter for the current phase; restarts when the phase changes.
module pwrcyc_span_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwrcyc_bx_gen.sv
`timescale 1ns/1ps
// Crossing-period generator, active only during acquisition.
module pwrcyc_bx_gen #(
  parameter int BX_PER = 34,
  parameter int N_BX   = 2820
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe,
  output logic last
);
  localparam int PH_W  = pwrcyc_pkg::cnt_width(BX_PER);
  localparam int IDX_W = pwrcyc_pkg::cnt_width(N_BX);

  logic [PH_W-1:0]  ph_q;
  logic [IDX_W-1:0] idx_q;
  logic             per_end;

  assign per_end = (ph_q == PH_W'(BX_PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (!run) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (per_end) begin
      ph_q  <= '0;
      idx_q <= idx_q + 1'b1;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  assign strobe = run && (ph_q == '0);
  assign last   = run && per_end && (idx_q == IDX_W'(N_BX - 1));
endmodule

// File: rtl/pwrcyc_err_cnt.sv
`timescale 1ns/1ps
// Saturating event counter.
module pwrcyc_err_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (inc && (cnt != '1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwrcyc_seq.sv
`timescale 1ns/1ps
module pwrcyc_seq #(
  parameter int BX_PER   = 34,
  parameter int N_BX     = 2820,
  parameter int WAKE_CYC = 2000,
  parameter int CONV_TO  = 50000,
  parameter int READ_TO  = 50000,
  parameter int ERR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start_i,
  input  logic             conv_done_i,
  input  logic             rd_done_i,
  output logic [2:0]       phase_o,
  output logic             pwr_ana_o,
  output logic             pwr_adc_o,
  output logic             pwr_dout_o,
  output logic             acq_o,
  output logic             bx_strobe_o,
  output logic             ovr_conv_o,
  output logic             ovr_read_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  import pwrcyc_pkg::*;

  localparam int SPAN_MAX = max3(WAKE_CYC, CONV_TO, READ_TO);
  localparam int SPAN_W   = cnt_width(SPAN_MAX);

  phase_e          phase_q, phase_nxt;
  dom_t            dom_q;
  logic [SPAN_W-1:0] span_cnt;
  logic            span_clr;
  logic            acq_run, acq_last;
  logic            wake_end, conv_end, read_end;
  // Named internal events for the checker.
  logic            conv_timeout, read_timeout, stray_start;
  logic            ovr_conv_q, ovr_read_q;

  assign wake_end = (span_cnt == SPAN_W'(WAKE_CYC - 1));
  assign conv_end = (span_cnt == SPAN_W'(CONV_TO - 1));
  assign read_end = (span_cnt == SPAN_W'(READ_TO - 1));

  assign conv_timeout = (phase_q == PH_CONV) && !conv_done_i && conv_end;
  assign read_timeout = (phase_q == PH_READ) && !rd_done_i && read_end;
  assign stray_start  = train_start_i && (phase_q != PH_IDLE);

  always_comb begin
    phase_nxt = phase_q;
    case (phase_q)
      PH_IDLE: if (train_start_i)                phase_nxt = PH_WAKE;
      PH_WAKE: if (wake_end)                     phase_nxt = PH_ACQ;
      PH_ACQ:  if (acq_last)                     phase_nxt = PH_CONV;
      PH_CONV: if (conv_done_i || conv_timeout)  phase_nxt = PH_READ;
      PH_READ: if (rd_done_i || read_timeout)    phase_nxt = PH_IDLE;
      default:                                   phase_nxt = PH_IDLE;
    endcase
  end

  assign span_clr = (phase_nxt != phase_q) || (phase_q == PH_IDLE);
  assign acq_run  = (phase_q == PH_ACQ);

  pwrcyc_span_cnt #(.W(SPAN_W)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (span_clr),
    .cnt   (span_cnt)
  );

  pwrcyc_bx_gen #(.BX_PER(BX_PER), .N_BX(N_BX)) u_bx (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (acq_run),
    .strobe (bx_strobe_o),
    .last   (acq_last)
  );

  pwrcyc_err_cnt #(.W(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stray_start),
    .cnt   (err_cnt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      dom_q      <= '0;
      ovr_conv_q <= 1'b0;
      ovr_read_q <= 1'b0;
    end else begin
      phase_q    <= phase_nxt;
      dom_q      <= dom_of(phase_nxt);
      if (conv_timeout) ovr_conv_q <= 1'b1;
      if (read_timeout) ovr_read_q <= 1'b1;
    end
  end

  assign phase_o    = phase_q;
  assign pwr_ana_o  = dom_q.ana;
  assign pwr_adc_o  = dom_q.adc;
  assign pwr_dout_o = dom_q.dout;
  assign acq_o      = acq_run;
  assign ovr_conv_o = ovr_conv_q;
  assign ovr_read_o = ovr_read_q;
endmodule

// File: rtl/pwrcyc_seq_chk.sv
`timescale 1ns/1ps
module pwrcyc_seq_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             train_start,
  input logic             conv_done,
  input logic             rd_done,
  input logic [2:0]       phase,
  input logic             pwr_ana,
  input logic             pwr_adc,
  input logic             pwr_dout,
  input logic             acq,
  input logic             bx_strobe,
  input logic             ovr_conv,
  input logic             ovr_read,
  input logic [ERR_W-1:0] err_cnt,
  input logic             conv_timeout,
  input logic             read_timeout,
  input logic             stray_start
);
  import pwrcyc_pkg::*;

  a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !(pwr_ana || pwr_adc || pwr_dout || acq));

  a_r11_one_domain: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_ana, pwr_adc, pwr_dout}));

  a_r4_strobe_in_acq: assert property (@(posedge clk) disable iff (!rst_n)
    bx_strobe |-> acq);

  a_r2_start_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && train_start) |=> (phase == PH_WAKE && pwr_ana));

  a_r3_acq_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq) |-> ($past(phase) == PH_WAKE));

  a_r5_conv_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && conv_done) |=> (phase == PH_READ && $stable(ovr_conv)));

  a_r6_conv_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout |=> (ovr_conv && phase == PH_READ));

  a_r6_conv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_conv |=> ovr_conv);

  a_r7_rd_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && rd_done) |=> (phase == PH_IDLE && $stable(ovr_read)));

  a_r8_read_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    read_timeout |=> (ovr_read && phase == PH_IDLE));

  a_r8_read_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_read |=> ovr_read);

  a_r9_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stray_start && err_cnt != '1) |=> (err_cnt == ERR_W'($past(err_cnt) + 1'b1)));

  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stray_start |=> $stable(err_cnt));
endmodule

bind pwrcyc_seq pwrcyc_seq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .train_start  (train_start_i),
  .conv_done    (conv_done_i),
  .rd_done      (rd_done_i),
  .phase        (phase_o),
  .pwr_ana      (pwr_ana_o),
  .pwr_adc      (pwr_adc_o),
  .pwr_dout     (pwr_dout_o),
  .acq          (acq_o),
  .bx_strobe    (bx_strobe_o),
  .ovr_conv     (ovr_conv_o),
  .ovr_read     (ovr_read_o),
  .err_cnt      (err_cnt_o),
  .conv_timeout (conv_timeout),
  .read_timeout (read_timeout),
  .stray_start  (stray_start)
);

// File: tb/pwrcyc_seq_bench.sv
`timescale 1ns/1ps
module pwrcyc_seq_bench;
  localparam int CLK_T = 10;
  localparam int W     = 5;
  localparam int BXP   = 3;
  localparam int NBX   = 4;
  localparam int CTO   = 6;
  localparam int RTO   = 7;
  localparam int EW    = 3;
  localparam int A     = BXP * NBX;

  typedef struct {
    logic [7:0] v;   // {phase[2:0], ana, adc, dout, acq, strobe}
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_start = 1'b0, conv_done = 1'b0, rd_done = 1'b0;
  logic [2:0] phase;
  logic ana, adc, dout, acq, stb, ovc, ovr;
  logic [EW-1:0] errc;

  int checks = 0;
  int fails  = 0;
  int exp_err = 0;
  bit exp_ovc = 0, exp_ovr = 0;
  item_t exp_q[$];

  always #(CLK_T/2) clk = ~clk;

  pwrcyc_seq #(.BX_PER(BXP), .N_BX(NBX), .WAKE_CYC(W), .CONV_TO(CTO),
               .READ_TO(RTO), .ERR_W(EW)) u_pwrcyc_seq (
    .clk(clk), .rst_n(rst_n), .train_start_i(train_start),
    .conv_done_i(conv_done), .rd_done_i(rd_done), .phase_o(phase),
    .pwr_ana_o(ana), .pwr_adc_o(adc), .pwr_dout_o(dout), .acq_o(acq),
    .bx_strobe_o(stb), .ovr_conv_o(ovc), .ovr_read_o(ovr), .err_cnt_o(errc));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] ph, input logic a, input logic c,
                      input logic d, input logic q, input logic s, input string req);
    item_t it;
    it.v = {ph, a, c, d, q, s};
    it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: compares one expected item per cycle, a quarter period after the edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_T/4);
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk({phase, ana, adc, dout, acq, stb} == it.v, it.req, "phase/enables/strobe",
            {phase, ana, adc, dout, acq, stb}, it.v);
        chk($countones({ana, adc, dout}) <= 1, "R11", "power domains", {ana, adc, dout}, 0);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_err = 0; exp_ovc = 0; exp_ovr = 0;
    @(negedge clk);
    chk(phase == 3'd0, "R1", "reset phase", phase, 0);
    chk({ana, adc, dout, acq, stb} == 5'b0, "R1", "reset outputs", {ana, adc, dout, acq, stb}, 0);
    chk({ovc, ovr} == 2'b0, "R1", "reset overrun flags", {ovc, ovr}, 0);
    chk(errc == '0, "R1", "reset error count", errc, 0);
  endtask

  // conv_lat/rd_lat < 0 means the done flag never arrives.
  task automatic run_train(input int conv_lat, input int rd_lat,
                           input int stray_n, input bit stray_done);
    int c, r, n, f0;
    c = (conv_lat < 0) ? CTO : conv_lat + 1;
    r = (rd_lat < 0) ? RTO : rd_lat + 1;
    n = W + A + c + r + 2;
    f0 = fails;
    @(negedge clk);
    for (int i = 0; i < W; i++) push(3'd1, 1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < A; i++) push(3'd2, 1, 0, 0, 1, (i % BXP) == 0, "R3/R4");
    for (int i = 0; i < c; i++) push(3'd3, 0, 1, 0, 0, 0, (conv_lat < 0) ? "R6" : "R5");
    for (int i = 0; i < r; i++) push(3'd4, 0, 0, 1, 0, 0, (rd_lat < 0) ? "R8" : "R7");
    for (int i = 0; i < 2; i++) push(3'd0, 0, 0, 0, 0, 0, "R1");
    train_start = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      train_start = (k >= 2) && (k < 2 + stray_n);
      conv_done = (conv_lat >= 0 && k == W + A + conv_lat + 1) ||
                  (stray_done && k == W + 2);
      rd_done   = (rd_lat >= 0 && k == W + A + c + rd_lat + 1) ||
                  (stray_done && (k == 2 || k == W + A + 1));
    end
    exp_err = exp_err + stray_n;
    if (exp_err > (1 << EW) - 1) exp_err = (1 << EW) - 1;
    if (conv_lat < 0) exp_ovc = 1;
    if (rd_lat < 0) exp_ovr = 1;
    chk(ovc == exp_ovc, (conv_lat < 0) ? "R6" : "R5", "conversion overrun flag", ovc, exp_ovc);
    chk(ovr == exp_ovr, (rd_lat < 0) ? "R8" : "R7", "readout overrun flag", ovr, exp_ovr);
    chk(errc == EW'(exp_err), "R9", "stray start count", errc, exp_err);
    if (stray_done)
      chk(fails == f0, "R10", "trace with stray done flags", fails - f0, 0);
  endtask

  initial begin
    #(CLK_T * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    run_train(CTO - 1, RTO - 1, 0, 0);  // R5 R7: done on the last allowed cycle
    run_train(2, 1, 0, 0);              // early done flags
    run_train(-1, 3, 2, 0);             // R6 timeout, R9 strays
    run_train(0, -1, 5, 1);             // R8 timeout, R9 saturation, R10 stray done
    run_train(1, 0, 1, 0);              // sticky flags held, count stays saturated
    do_reset();                         // R1: flags cleared only by reset
    run_train(3, 2, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule